// File: doc/BRIEF.md
# CAN Nominal Bit Timer

This block turns the system clock into the time base of a CAN node. A programmable prescaler divides the clock into time quanta. A small segment sequencer then walks each nominal bit through a one-quantum synchronization segment, a first timing segment and a second timing segment. The first timing segment holds the propagation delay and phase segment 1. The second timing segment is phase segment 2. The sequencer advances once per quantum. The sample point lies where the first timing segment meets the second.

The surrounding protocol engine uses three outputs. The sample strobe comes with the sampled receive level. The transmit strobe marks where the next bit goes onto the line. The quantum tick is also brought out. A mode input selects how the block reacts to a recessive-to-dominant transition on the receive line. In one mode it restarts the bit outright (hard synchronization). In the other it stretches or trims the phase segments by at most the jump width (resynchronization). Every length field is programmed as its functional value minus one.

Top module: `can_bit_timer`

## Requirements
- R1: One quantum lasts {brpe_i, brpe_i is the upper 4 bits and brp_i the lower 6 bits} + 1 clock cycles. `tq_tick_o` is high for exactly one cycle per quantum, and it stays high continuously when that value is 1.
- R2: When the receive line has no falling edge, `tx_point_o` pulses once per bit, and consecutive pulses are tseg1_i + tseg2_i + 3 quanta apart.
- R3: `sample_o` is a one-cycle pulse tseg1_i + 2 quanta after the preceding `tx_point_o` pulse. Each strobe appears in the cycle after the quantum tick that closes its segment, so the two strobes are never high together.
- R4: `sample_bit_o` takes the level of `rx_i` at the tick that closes the first timing segment. It changes only together with `sample_o` and is 1 after reset.
- R5: During reset both strobes are low and `sample_bit_o` is 1. After reset the first quantum is the synchronization segment, so the first `tx_point_o` comes one full bit after reset is released.
- R6: A falling edge means `rx_i` is 1 at one quantum tick and 0 at the next. With `hard_sync_i` = 0, a falling edge seen at the tick that closes the synchronization segment has no effect.
- R7: With `hard_sync_i` = 0, a falling edge seen at the tick closing quantum k (k = 1 for the first) of the first timing segment lengthens that segment by min(k, sjw_i + 1) quanta.
- R8: With `hard_sync_i` = 0, a falling edge seen while r quanta of the second timing segment still remain after the current one shortens that segment by min(r, sjw_i + 1). If nothing remains, the bit ends at that tick with a `tx_point_o` pulse.
- R9: With `hard_sync_i` = 1, a falling edge in any segment makes its quantum act as the synchronization segment. The next `sample_o` then comes tseg1_i + 1 quanta later, and no `tx_point_o` is issued for the abandoned bit.
- R10: After one synchronization, further falling edges are ignored until the next sample point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| brp_i | input | 6 | Prescaler low bits, value minus one |
| brpe_i | input | 4 | Prescaler extension, upper bits |
| tseg1_i | input | 4 | First timing segment length minus one |
| tseg2_i | input | 3 | Second timing segment length minus one |
| sjw_i | input | 2 | Jump width minus one |
| hard_sync_i | input | 1 | 1: hard synchronization, 0: resynchronization |
| rx_i | input | 1 | Receive line, 1 = recessive |
| tq_tick_o | output | 1 | One pulse per time quantum |
| sample_o | output | 1 | Sample-point strobe |
| sample_bit_o | output | 1 | Level captured at the last sample point |
| tx_point_o | output | 1 | Strobe at the start of the synchronization segment |

## Verification
The assertions assume the configuration fields are stable across the windows they examine. They also assume the jump width is no longer than either phase segment, that is sjw_i + 1 is at most tseg2_i + 1 and at most tseg1_i. The stimulus changes configuration only just after a transmit strobe and then lets a full bit pass before it measures anything. All edge tests use a 7/3 segment split, which keeps every jump width from 1 to 4 inside that limit. The receive line is driven between clock edges and is held low until the measured strobe has been seen.

// File: rtl/bt_pkg.sv
package bt_pkg;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_TS1  = 2'd1,
        SEG_TS2  = 2'd2
    } seg_e;

endpackage

// File: rtl/bt_quantum_gen.sv
module bt_quantum_gen #(
    parameter int BRP_W  = 6,
    parameter int BRPE_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [BRP_W-1:0]  brp_i,
    input  logic [BRPE_W-1:0] brpe_i,
    output logic              tick_o
);
    localparam int CNT_W = BRP_W + BRPE_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } qg_state_t;

    qg_state_t        st_d, st_q;
    logic [CNT_W-1:0] reload;

    always_comb begin
        reload = {brpe_i, brp_i};
        st_d   = st_q;
        // >= so that a shrinking reload value never strands the counter
        tick_o = (st_q.cnt >= reload);
        if (tick_o) st_d.cnt = '0;
        else        st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R1: with a divide ratio above one and a steady setting, ticks never touch
    a_r1_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && reload != '0) |=> (!tick_o || reload != $past(reload)));

endmodule

// File: rtl/bt_fall_det.sv
module bt_fall_det (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic rx_i,
    output logic fall_o
);
    typedef struct packed {
        logic last;
    } fd_state_t;

    fd_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        fall_o = tick_i && st_q.last && !rx_i;
        if (tick_i) st_d.last = rx_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '{last: 1'b1};
        else         st_q <= st_d;
    end

endmodule

// File: rtl/bt_seg_fsm.sv
module bt_seg_fsm
    import bt_pkg::*;
#(
    parameter int TSEG1_W = 4,
    parameter int TSEG2_W = 3,
    parameter int SJW_W   = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               tick_i,
    input  logic               fall_i,
    input  logic               rx_i,
    input  logic               hard_sync_i,
    input  logic [TSEG1_W-1:0] tseg1_i,
    input  logic [TSEG2_W-1:0] tseg2_i,
    input  logic [SJW_W-1:0]   sjw_i,
    output logic               sample_o,
    output logic               sample_bit_o,
    output logic               tx_point_o
);
    localparam int MAX12 = (TSEG1_W > TSEG2_W) ? TSEG1_W : TSEG2_W;
    localparam int MAXW  = (MAX12 > SJW_W) ? MAX12 : SJW_W;
    localparam int CW    = MAXW + 2;

    typedef struct packed {
        seg_e          seg;
        logic [CW-1:0] cnt;
        logic [CW-1:0] len1;
        logic [CW-1:0] len2;
        logic          synced;
        logic          sample;
        logic          sbit;
        logic          txp;
    } sf_state_t;

    sf_state_t     st_d, st_q;
    logic [CW-1:0] sjw_f, nom1, nom2, len_eff, rem, cut;
    logic          can_sync;

    function automatic logic [CW-1:0] min_cw(input logic [CW-1:0] a, input logic [CW-1:0] b);
        return (a < b) ? a : b;
    endfunction

    always_comb begin
        st_d        = st_q;
        st_d.sample = 1'b0;
        st_d.txp    = 1'b0;
        sjw_f       = CW'(sjw_i) + CW'(1);
        nom1        = CW'(tseg1_i) + CW'(1);
        nom2        = CW'(tseg2_i) + CW'(1);
        can_sync    = fall_i && !st_q.synced;
        len_eff     = st_q.len1;
        rem         = st_q.len2 - CW'(1) - st_q.cnt;
        cut         = '0;
        if (tick_i) begin
            case (st_q.seg)
                SEG_SYNC: begin
                    st_d.seg  = SEG_TS1;
                    st_d.cnt  = '0;
                    st_d.len1 = nom1;
                    if (can_sync && hard_sync_i) st_d.synced = 1'b1;
                end
                SEG_TS1: begin
                    if (can_sync && hard_sync_i) begin
                        st_d.seg    = SEG_TS1;
                        st_d.cnt    = '0;
                        st_d.len1   = nom1;
                        st_d.synced = 1'b1;
                    end else begin
                        if (can_sync) begin
                            len_eff     = st_q.len1 + min_cw(st_q.cnt + CW'(1), sjw_f);
                            st_d.len1   = len_eff;
                            st_d.synced = 1'b1;
                        end
                        if (st_q.cnt == len_eff - CW'(1)) begin
                            st_d.seg    = SEG_TS2;
                            st_d.cnt    = '0;
                            st_d.len2   = nom2;
                            st_d.sample = 1'b1;
                            st_d.sbit   = rx_i;
                            st_d.synced = 1'b0;
                        end else begin
                            st_d.cnt = st_q.cnt + CW'(1);
                        end
                    end
                end
                SEG_TS2: begin
                    if (can_sync && hard_sync_i) begin
                        st_d.seg    = SEG_TS1;
                        st_d.cnt    = '0;
                        st_d.len1   = nom1;
                        st_d.synced = 1'b1;
                    end else begin
                        if (can_sync) begin
                            cut         = min_cw(rem, sjw_f);
                            st_d.synced = 1'b1;
                        end
                        if (rem == cut) begin
                            st_d.seg = SEG_SYNC;
                            st_d.cnt = '0;
                            st_d.txp = 1'b1;
                        end else begin
                            st_d.len2 = st_q.len2 - cut;
                            st_d.cnt  = st_q.cnt + CW'(1);
                        end
                    end
                end
                default: begin
                    st_d.seg = SEG_SYNC;
                    st_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.seg    <= SEG_SYNC;
            st_q.cnt    <= '0;
            st_q.len1   <= CW'(1);
            st_q.len2   <= CW'(1);
            st_q.synced <= 1'b0;
            st_q.sample <= 1'b0;
            st_q.sbit   <= 1'b1;
            st_q.txp    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample_o     = st_q.sample;
    assign sample_bit_o = st_q.sbit;
    assign tx_point_o   = st_q.txp;

    // R3: the sample strobe always follows a quantum tick
    a_r3_sample_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_o |-> $past(tick_i));

    // R2: the transmit strobe always follows a quantum tick
    a_r2_tx_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_point_o |-> $past(tick_i));

    // R3: the two strobes close different segments
    a_r3_strobes_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sample_o && tx_point_o));

    // R4: the captured level moves only with a sample strobe
    a_r4_bit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sample_o |-> $stable(sample_bit_o));

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
    parameter int BRP_W   = 6,
    parameter int BRPE_W  = 4,
    parameter int TSEG1_W = 4,
    parameter int TSEG2_W = 3,
    parameter int SJW_W   = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [BRP_W-1:0]   brp_i,
    input  logic [BRPE_W-1:0]  brpe_i,
    input  logic [TSEG1_W-1:0] tseg1_i,
    input  logic [TSEG2_W-1:0] tseg2_i,
    input  logic [SJW_W-1:0]   sjw_i,
    input  logic               hard_sync_i,
    input  logic               rx_i,
    output logic               tq_tick_o,
    output logic               sample_o,
    output logic               sample_bit_o,
    output logic               tx_point_o
);
    logic tick;
    logic fall;

    bt_quantum_gen #(
        .BRP_W  (BRP_W),
        .BRPE_W (BRPE_W)
    ) u_qgen (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .brp_i  (brp_i),
        .brpe_i (brpe_i),
        .tick_o (tick)
    );

    bt_fall_det u_fall (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick),
        .rx_i   (rx_i),
        .fall_o (fall)
    );

    bt_seg_fsm #(
        .TSEG1_W (TSEG1_W),
        .TSEG2_W (TSEG2_W),
        .SJW_W   (SJW_W)
    ) u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tick_i       (tick),
        .fall_i       (fall),
        .rx_i         (rx_i),
        .hard_sync_i  (hard_sync_i),
        .tseg1_i      (tseg1_i),
        .tseg2_i      (tseg2_i),
        .sjw_i        (sjw_i),
        .sample_o     (sample_o),
        .sample_bit_o (sample_bit_o),
        .tx_point_o   (tx_point_o)
    );

    assign tq_tick_o = tick;

endmodule

// File: tb/can_bit_timer_bench.sv
`timescale 1ns/1ps
module can_bit_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] brp = '0;
    logic [3:0] brpe = '0;
    logic [3:0] tseg1 = 4'd7;
    logic [2:0] tseg2 = 3'd3;
    logic [1:0] sjw = 2'd3;
    logic       hard = 1'b0;
    logic       rx = 1'b1;
    logic       tq_tick, smp, smp_bit, txp;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int tx_seen = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    can_bit_timer u_can_bit_timer (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .brp_i        (brp),
        .brpe_i       (brpe),
        .tseg1_i      (tseg1),
        .tseg2_i      (tseg2),
        .sjw_i        (sjw),
        .hard_sync_i  (hard),
        .rx_i         (rx),
        .tq_tick_o    (tq_tick),
        .sample_o     (smp),
        .sample_bit_o (smp_bit),
        .tx_point_o   (txp)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_tx(output int t);
        do @(negedge clk); while (!txp);
        t = cyc;
    endtask

    task automatic wait_sample(output int t);
        tx_seen = 0;
        @(negedge clk);
        while (!smp) begin
            if (txp) tx_seen++;
            @(negedge clk);
        end
        t = cyc;
    endtask

    task automatic tick_gap(output int g);
        int t1;
        do @(negedge clk); while (!tq_tick);
        t1 = cyc;
        do @(negedge clk); while (!tq_tick);
        g = cyc - t1;
    endtask

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int ta, tb, ts, g;
        // R5: reset state
        repeat (3) @(negedge clk);
        chk("R5 sample low in reset", int'(smp), 0);
        chk("R5 tx low in reset", int'(txp), 0);
        chk("R5 sample bit high in reset", int'(smp_bit), 1);
        rst_n = 1'b1;
        ta = cyc;
        wait_tx(tb);
        chk("R5 first bit length", tb - ta, 13);

        // R1: prescaler sweep
        for (int i = 0; i < 6; i++) begin
            int n;
            case (i)
                0: begin brpe = 4'd0;  brp = 6'd0;  end
                1: begin brpe = 4'd0;  brp = 6'd1;  end
                2: begin brpe = 4'd0;  brp = 6'd5;  end
                3: begin brpe = 4'd0;  brp = 6'd63; end
                4: begin brpe = 4'd1;  brp = 6'd0;  end
                default: begin brpe = 4'd15; brp = 6'd63; end
            endcase
            n = {brpe, brp} + 1;
            tick_gap(g);
            tick_gap(g);
            chk("R1 quantum length", g, n);
        end
        brpe = 4'd0;

        // R2, R3, R4: segment sweep with a quiet line
        for (int n = 1; n <= 3; n += 2) begin
            brp = 6'(n - 1);
            for (int t1 = 0; t1 < 16; t1++) begin
                for (int t2 = 0; t2 < 8; t2++) begin
                    tseg1 = 4'(t1);
                    tseg2 = 3'(t2);
                    wait_tx(ta);
                    wait_tx(ta);
                    wait_sample(ts);
                    chk("R3 sample position", ts - ta, (t1 + 2) * n);
                    chk("R4 sampled recessive", int'(smp_bit), 1);
                    wait_tx(tb);
                    chk("R2 bit length", tb - ta, (t1 + t2 + 3) * n);
                end
            end
        end

        // R6, R7, R8: resynchronization, 7/3 split
        brp = 6'd0; tseg1 = 4'd7; tseg2 = 3'd3; hard = 1'b0;
        for (int s = 0; s < 4; s++) begin
            sjw = 2'(s);
            for (int d = 0; d <= 12; d++) begin
                wait_tx(ta);
                wait_tx(ta);
                wait_tx(ta);
                repeat (d) @(negedge clk);
                rx = 1'b0;
                if (d == 0) begin
                    wait_sample(ts);
                    chk("R6 edge in sync segment ignored", ts - ta, 9);
                    chk("R4 sampled dominant", int'(smp_bit), 0);
                end else if (d <= 8) begin
                    wait_sample(ts);
                    chk("R7 first segment lengthened", ts - ta, 9 + imin(d, s + 1));
                    chk("R4 sampled dominant", int'(smp_bit), 0);
                end else begin
                    wait_tx(tb);
                    chk("R8 second segment shortened", tb - ta, 13 - imin(3 - (d - 9), s + 1));
                end
                rx = 1'b1;
            end
        end

        // R10: second edge before the sample point, resync mode
        sjw = 2'd3;
        wait_tx(ta); wait_tx(ta); wait_tx(ta);
        repeat (2) @(negedge clk); rx = 1'b0;
        @(negedge clk); rx = 1'b1;
        repeat (2) @(negedge clk); rx = 1'b0;
        wait_sample(ts);
        chk("R10 second resync ignored", ts - ta, 11);
        rx = 1'b1;

        // R9: hard synchronization in every segment
        hard = 1'b1;
        for (int d = 0; d <= 12; d++) begin
            wait_tx(ta);
            wait_tx(ta);
            wait_tx(ta);
            repeat (d) @(negedge clk);
            rx = 1'b0;
            wait_sample(ts);
            chk("R9 hard sync restart", ts - ta, d + 9);
            chk("R9 no tx strobe for abandoned bit", tx_seen, 0);
            rx = 1'b1;
        end

        // R10: second edge before the sample point, hard mode
        wait_tx(ta); wait_tx(ta); wait_tx(ta);
        repeat (2) @(negedge clk); rx = 1'b0;
        @(negedge clk); rx = 1'b1;
        @(negedge clk); rx = 1'b0;
        wait_sample(ts);
        chk("R10 second hard sync ignored", ts - ta, 11);
        rx = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule